// File: doc/BRIEF.md
# Multi-Queue Shared-Memory FIFO

This block holds several independent first-in first-out queues inside one data memory. The memory is divided into equal blocks. At reset each queue is given a whole number of those blocks as one contiguous region, so every queue depth is a multiple of the block size. A queue may be given no blocks at all. A single write port and a single read port are shared by all queues. Each port has its own queue-select address, a select strobe and an active-low data enable, and each port has its own queue-select register.

The write port shows full and almost-full for the queue selected on it. The read port works in first-word-fall-through fashion: the head word of the selected queue appears on the output with an output-valid flag, and no read enable is needed for it. Each enabled read consumes the word on display. The read port also shows almost-empty for its selected queue. Each queue has its own almost-full and almost-empty thresholds. The block counts and the thresholds are captured during a synchronous reset. The whole block runs on a single clock.

Top module: `mq_shared_fifo`

## Requirements
- R1: During reset, queue n (0 first) is given the next `cfg_blocks[n]` blocks after those of queues 0..n-1, each field being BCW bits wide at bit n*BCW. If fewer blocks remain than requested, the queue gets only the remainder. A queue with zero blocks always shows `full`, ignores writes and never raises `out_valid`.
- R2: When `wr_sel_en` is high at a clock edge, the write queue becomes `wr_qsel`. A write at that same edge still goes to the previously selected queue. Writes from the next edge onward go to the new queue. A selection takes effect whatever the state of `wr_en_n`.
- R3: `full` is high exactly when the occupancy of the write-selected queue equals its depth. A write (`wr_en_n` low) while `full` is high is dropped and leaves the stored data unchanged.
- R4: `almost_full` is high when the occupancy plus that queue's almost-full threshold (field n of `af_thr`, CW bits at bit n*CW) is at least the queue depth.
- R5: Once a word is stored in the read-selected queue, it appears on `rd_data` with `out_valid` high after one further clock edge, with no read enable. An edge with `out_valid` high and `rd_en_n` low consumes the displayed word. The next word, if any, is displayed after that same edge.
- R6: An edge with `rd_sel_en` high makes `rd_qsel` the read queue. For the following cycle it drops `out_valid` and keeps `rd_data` unchanged. The cycle after that shows the new queue's head word if the queue is non-empty. If the queue is empty, the previous word stays on `rd_data` with `out_valid` low.
- R7: `almost_empty` is high when the occupancy of the read-selected queue is at or below its almost-empty threshold (field n of `ae_thr`).
- R8: A write and a read that hit the same queue at one edge leave its occupancy unchanged, and the order of the words is kept.
- R9: Read and write pointers wrap inside each queue's own region, so FIFO order holds across the wrap.
- R10: After reset both selected queues are queue 0, `out_valid` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cfg_blocks | input | NUM_Q*BCW | Block count per queue |
| af_thr | input | NUM_Q*CW | Almost-full threshold per queue |
| ae_thr | input | NUM_Q*CW | Almost-empty threshold per queue |
| wr_qsel | input | QW | Write queue address |
| wr_sel_en | input | 1 | Loads the write queue address |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DW | Write data |
| full | output | 1 | Write-selected queue is full |
| almost_full | output | 1 | Write-selected queue is at or above its almost-full level |
| rd_qsel | input | QW | Read queue address |
| rd_sel_en | input | 1 | Loads the read queue address |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DW | Output register |
| out_valid | output | 1 | `rd_data` holds the head word of the read-selected queue |
| almost_empty | output | 1 | Read-selected queue is at or below its almost-empty level |

## Verification
The bench builds the block with 4 queues, 8 blocks of 4 words and 16-bit data. The requested block counts are 2, 1, 0 and 6. Queue 2 therefore gets no memory, and the request for queue 3 is cut to the 5 blocks that remain, giving 20 words. The small blocks let full be reached in a handful of writes, and they make the 4-word queue wrap its pointers within a few operations. A zero-depth queue and the clamping of an over-large request are both exercised under these settings.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // What the read output register does at the next edge
    typedef enum logic {
        RO_DROP = 1'b0,  // keep the word, clear valid
        RO_LOAD = 1'b1   // load the head word of the selected queue
    } rd_act_e;

endpackage

// File: rtl/mq_region_map.sv
module mq_region_map #(
    parameter int NUM_Q     = 4,
    parameter int NUM_BLK   = 16,
    parameter int BLK_WORDS = 32,
    parameter int BCW       = 5,
    parameter int AW        = 9,
    parameter int CW        = 10
) (
    input  logic [NUM_Q*BCW-1:0] blk_cnt_i,
    output logic [NUM_Q*AW-1:0]  base_o,
    output logic [NUM_Q*CW-1:0]  depth_o
);

    always_comb begin
        int used;
        int want;
        int take;
        used    = 0;
        base_o  = '0;
        depth_o = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            want = int'(blk_cnt_i[q*BCW +: BCW]);
            take = (want > NUM_BLK - used) ? (NUM_BLK - used) : want;
            base_o[q*AW +: AW]  = AW'(used * BLK_WORDS);
            depth_o[q*CW +: CW] = CW'(take * BLK_WORDS);
            used = used + take;
        end
    end

endmodule

// File: rtl/mq_ptr_bank.sv
module mq_ptr_bank #(
    parameter int NUM_Q = 4,
    parameter int QW    = 2,
    parameter int CW    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_Q*CW-1:0] depth_i,
    input  logic                wr_go_i,
    input  logic [QW-1:0]       wr_q_i,
    input  logic                rd_go_i,
    input  logic [QW-1:0]       rd_q_i,
    output logic [NUM_Q*CW-1:0] cnt_o,
    output logic [CW-1:0]       wofs_sel_o,
    output logic [CW-1:0]       rofs_nxt_sel_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] wofs;
        logic [CW-1:0] rofs;
    } qptr_t;

    logic [NUM_Q*CW-1:0] wofs_all;
    logic [NUM_Q*CW-1:0] rofs_nxt_all;

    for (genvar gq = 0; gq < NUM_Q; gq++) begin : g_q
        qptr_t         p_d, p_q;
        logic          inc, dec;
        logic [CW-1:0] dep, w_inc, r_inc;

        assign dep = depth_i[gq*CW +: CW];
        assign inc = wr_go_i && (wr_q_i == QW'(gq));
        assign dec = rd_go_i && (rd_q_i == QW'(gq));

        always_comb begin
            p_d   = p_q;
            w_inc = p_q.wofs + CW'(1);
            r_inc = p_q.rofs + CW'(1);
            if (!rst_n) begin
                p_d = '0;
            end else begin
                if (inc) begin
                    p_d.wofs = (w_inc == dep) ? '0 : w_inc;
                end
                if (dec) begin
                    p_d.rofs = (r_inc == dep) ? '0 : r_inc;
                end
                p_d.cnt = p_q.cnt + CW'(inc) - CW'(dec);
            end
        end

        always_ff @(posedge clk) begin
            p_q <= p_d;
        end

        assign cnt_o[gq*CW +: CW]        = p_q.cnt;
        assign wofs_all[gq*CW +: CW]     = p_q.wofs;
        assign rofs_nxt_all[gq*CW +: CW] = (rst_n && dec) ? p_d.rofs : p_q.rofs;
    end

    assign wofs_sel_o     = wofs_all[int'(wr_q_i)*CW +: CW];
    assign rofs_nxt_sel_o = rofs_nxt_all[int'(rd_q_i)*CW +: CW];

endmodule

// File: rtl/mq_data_store.sv
module mq_data_store #(
    parameter int DW    = 16,
    parameter int AW    = 9,
    parameter int WORDS = 512
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/mq_shared_fifo.sv
module mq_shared_fifo #(
    parameter int NUM_Q     = 4,
    parameter int NUM_BLK   = 16,
    parameter int BLK_WORDS = 32,
    parameter int DW        = 16,
    localparam int QW       = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int TOTAL    = NUM_BLK * BLK_WORDS,
    localparam int AW       = (TOTAL > 1) ? $clog2(TOTAL) : 1,
    localparam int CW       = $clog2(TOTAL + 1),
    localparam int BCW      = $clog2(NUM_BLK + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_Q*BCW-1:0] cfg_blocks,
    input  logic [NUM_Q*CW-1:0]  af_thr,
    input  logic [NUM_Q*CW-1:0]  ae_thr,
    input  logic [QW-1:0]        wr_qsel,
    input  logic                 wr_sel_en,
    input  logic                 wr_en_n,
    input  logic [DW-1:0]        wr_data,
    output logic                 full,
    output logic                 almost_full,
    input  logic [QW-1:0]        rd_qsel,
    input  logic                 rd_sel_en,
    input  logic                 rd_en_n,
    output logic [DW-1:0]        rd_data,
    output logic                 out_valid,
    output logic                 almost_empty
);

    import mq_pkg::*;

    typedef struct packed {
        logic [NUM_Q*BCW-1:0] blk;
        logic [NUM_Q*CW-1:0]  af;
        logic [NUM_Q*CW-1:0]  ae;
        logic [QW-1:0]        wq;
        logic [QW-1:0]        rq;
        logic [DW-1:0]        dout;
        logic                 ovalid;
    } st_t;

    st_t s_d, s_q;

    logic [NUM_Q*AW-1:0] base_all;
    logic [NUM_Q*CW-1:0] depth_all;
    logic [NUM_Q*CW-1:0] cnt_all;
    logic [CW-1:0]       wofs_sel, rofs_nxt_sel;
    logic [CW-1:0]       cnt_w, dep_w, af_w, cnt_r, ae_r, avail_r;
    logic [AW-1:0]       base_w, base_r, waddr, raddr;
    logic [DW-1:0]       head_word;
    logic                full_c, wr_go, rd_go;
    rd_act_e             rd_act;

    mq_region_map #(
        .NUM_Q(NUM_Q), .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS),
        .BCW(BCW), .AW(AW), .CW(CW)
    ) u_map (
        .blk_cnt_i (s_q.blk),
        .base_o    (base_all),
        .depth_o   (depth_all)
    );

    mq_ptr_bank #(.NUM_Q(NUM_Q), .QW(QW), .CW(CW)) u_ptrs (
        .clk            (clk),
        .rst_n          (rst_n),
        .depth_i        (depth_all),
        .wr_go_i        (wr_go),
        .wr_q_i         (s_q.wq),
        .rd_go_i        (rd_go),
        .rd_q_i         (s_q.rq),
        .cnt_o          (cnt_all),
        .wofs_sel_o     (wofs_sel),
        .rofs_nxt_sel_o (rofs_nxt_sel)
    );

    mq_data_store #(.DW(DW), .AW(AW), .WORDS(TOTAL)) u_mem (
        .clk     (clk),
        .we_i    (wr_go),
        .waddr_i (waddr),
        .wdata_i (wr_data),
        .raddr_i (raddr),
        .rdata_o (head_word)
    );

    // Per-port views of the selected queue
    always_comb begin
        cnt_w  = cnt_all[int'(s_q.wq)*CW +: CW];
        dep_w  = depth_all[int'(s_q.wq)*CW +: CW];
        af_w   = s_q.af[int'(s_q.wq)*CW +: CW];
        base_w = base_all[int'(s_q.wq)*AW +: AW];
        cnt_r  = cnt_all[int'(s_q.rq)*CW +: CW];
        ae_r   = s_q.ae[int'(s_q.rq)*CW +: CW];
        base_r = base_all[int'(s_q.rq)*AW +: AW];
    end

    assign full_c  = (cnt_w >= dep_w);
    assign wr_go   = rst_n && !wr_en_n && !full_c;
    assign rd_go   = rst_n && s_q.ovalid && !rd_en_n;
    assign avail_r = cnt_r - CW'(rd_go);
    assign waddr   = base_w + AW'(wofs_sel);
    assign raddr   = base_r + AW'(rofs_nxt_sel);

    always_comb begin
        s_d    = s_q;
        rd_act = RO_DROP;
        if (!rst_n) begin
            s_d.blk    = cfg_blocks;
            s_d.af     = af_thr;
            s_d.ae     = ae_thr;
            s_d.wq     = '0;
            s_d.rq     = '0;
            s_d.dout   = '0;
            s_d.ovalid = 1'b0;
        end else begin
            if (wr_sel_en) begin
                s_d.wq = wr_qsel;
            end
            if (rd_sel_en) begin
                s_d.rq = rd_qsel;
                rd_act = RO_DROP;
            end else if (avail_r != '0) begin
                rd_act = RO_LOAD;
            end else begin
                rd_act = RO_DROP;
            end
            case (rd_act)
                RO_LOAD: begin
                    s_d.dout   = head_word;
                    s_d.ovalid = 1'b1;
                end
                default: begin
                    s_d.ovalid = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign full         = full_c;
    assign almost_full  = ({1'b0, cnt_w} + {1'b0, af_w}) >= {1'b0, dep_w};
    assign almost_empty = (cnt_r <= ae_r);
    assign rd_data      = s_q.dout;
    assign out_valid    = s_q.ovalid;

endmodule

// File: rtl/mq_shared_fifo_chk.sv
module mq_shared_fifo_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_sel_en,
    input logic          rd_en_n,
    input logic          rd_sel_en,
    input logic          full,
    input logic          almost_full,
    input logic          out_valid,
    input logic [DW-1:0] rd_data
);

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_en_n && !wr_sel_en) |=> full); // R3

    AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full); // R4

    AST_SEL_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_en |=> (!out_valid && $stable(rd_data))); // R6

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rd_en_n && !rd_sel_en) |=> (out_valid && $stable(rd_data))); // R5

endmodule

bind mq_shared_fifo mq_shared_fifo_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_sel_en   (wr_sel_en),
    .rd_en_n     (rd_en_n),
    .rd_sel_en   (rd_sel_en),
    .full        (full),
    .almost_full (almost_full),
    .out_valid   (out_valid),
    .rd_data     (rd_data)
);

// File: tb/mq_shared_fifo_test.sv
`timescale 1ns/1ps
module mq_shared_fifo_test;

    localparam int NUM_Q = 4, NUM_BLK = 8, BLK_WORDS = 4, DW = 16;
    localparam int QW  = 2;
    localparam int CW  = $clog2(NUM_BLK * BLK_WORDS + 1);
    localparam int BCW = $clog2(NUM_BLK + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_Q*BCW-1:0] cfg_blocks;
    logic [NUM_Q*CW-1:0]  af_thr, ae_thr;
    logic [QW-1:0] wr_qsel = '0, rd_qsel = '0;
    logic wr_sel_en = 1'b0, wr_en_n = 1'b1, rd_sel_en = 1'b0, rd_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full, almost_full, out_valid, almost_empty;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    assign cfg_blocks = {BCW'(6), BCW'(0), BCW'(1), BCW'(2)};
    assign af_thr     = {CW'(0), CW'(0), CW'(1), CW'(2)};
    assign ae_thr     = {CW'(0), CW'(0), CW'(2), CW'(1)};

    mq_shared_fifo #(.NUM_Q(NUM_Q), .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_blocks(cfg_blocks), .af_thr(af_thr), .ae_thr(ae_thr),
        .wr_qsel(wr_qsel), .wr_sel_en(wr_sel_en), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .full(full), .almost_full(almost_full),
        .rd_qsel(rd_qsel), .rd_sel_en(rd_sel_en), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .out_valid(out_valid), .almost_empty(almost_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        wr_data = d; wr_en_n = 1'b0;
        tick();
        wr_en_n = 1'b1;
    endtask

    task automatic rd(input string req, input logic [DW-1:0] exp);
        chk({req, " valid"}, out_valid, 1);
        chk({req, " data"}, rd_data, exp);
        rd_en_n = 1'b0;
        tick();
        rd_en_n = 1'b1;
    endtask

    task automatic sel_wr(input logic [QW-1:0] q);
        wr_sel_en = 1'b1; wr_qsel = q;
        tick();
        wr_sel_en = 1'b0;
    endtask

    task automatic sel_rd(input logic [QW-1:0] q);
        rd_sel_en = 1'b1; rd_qsel = q;
        tick();
        rd_sel_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 out_valid", out_valid, 0);
        chk("R10 rd_data", rd_data, 0);
        chk("R10 full q0", full, 0);
        chk("R10 almost_full q0", almost_full, 0);
        chk("R7 almost_empty empty q0", almost_empty, 1);
    endtask

    task automatic t_fill_drain_q0();
        for (int i = 0; i < 8; i++) begin
            wr(16'h0100 + 16'(i));
            if (i == 4) chk("R4 af at 5 of 8", almost_full, 0);
            if (i == 5) chk("R4 af at 6 of 8", almost_full, 1);
            if (i == 6) chk("R3 full at 7 of 8", full, 0);
            if (i == 7) chk("R3 full at 8 of 8", full, 1);
        end
        wr(16'hDEAD);
        chk("R3 still full after dropped write", full, 1);
        chk("R7 ae q0 at 8", almost_empty, 0);
        for (int i = 0; i < 8; i++) begin
            rd("R5 q0 order", 16'h0100 + 16'(i));
            if (i == 0) chk("R3 full clears after read", full, 0);
            chk("R7 ae q0 drain", almost_empty, ((7 - i) <= 1) ? 1 : 0);
        end
        chk("R3 dropped word absent, valid", out_valid, 0);
        chk("R3 dropped word absent, data", rd_data, 16'h0107);
    endtask

    task automatic t_select_latency();
        wr_sel_en = 1'b1; wr_qsel = 2'd1; wr_data = 16'h0200; wr_en_n = 1'b0;
        tick();
        wr_sel_en = 1'b0; wr_data = 16'h0201;
        tick();
        wr_en_n = 1'b1;
        tick();
        rd("R2 same-edge write to old queue", 16'h0200);
        chk("R2 old queue holds one word", out_valid, 0);
        sel_rd(2'd1);
        chk("R6 valid drops on select", out_valid, 0);
        chk("R6 data held on select", rd_data, 16'h0200);
        tick();
        chk("R5 fall-through valid", out_valid, 1);
        chk("R2 next write reached new queue", rd_data, 16'h0201);
    endtask

    task automatic t_wrap_q1();
        wr(16'h0202); wr(16'h0203); wr(16'h0204);
        chk("R3 q1 full at 4", full, 1);
        rd("R9 q1", 16'h0201);
        rd("R9 q1", 16'h0202);
        wr(16'h0205); wr(16'h0206);
        chk("R9 q1 full after wrap", full, 1);
        for (int i = 3; i <= 6; i++) rd("R9 q1 wrap order", 16'h0200 + 16'(i));
        chk("R9 q1 empty", out_valid, 0);
    endtask

    task automatic t_same_queue_rw();
        wr(16'h0300);
        tick();
        chk("R5 q1 head", rd_data, 16'h0300);
        wr_data = 16'h0301; wr_en_n = 1'b0; rd_en_n = 1'b0;
        tick();
        wr_en_n = 1'b1; rd_en_n = 1'b1;
        chk("R8 ae at occupancy 1", almost_empty, 1);
        tick();
        chk("R8 next word valid", out_valid, 1);
        chk("R8 next word", rd_data, 16'h0301);
        wr(16'h0302); wr(16'h0303);
        chk("R4 q1 af at 3", almost_full, 1);
        wr_data = 16'h0304; wr_en_n = 1'b0; rd_en_n = 1'b0;
        tick();
        wr_en_n = 1'b1; rd_en_n = 1'b1;
        chk("R8 occupancy kept, not full", full, 0);
        chk("R8 occupancy kept, af", almost_full, 1);
        wr(16'h0305);
        chk("R8 full at 4", full, 1);
        for (int i = 2; i <= 5; i++) rd("R8 order", 16'h0300 + 16'(i));
    endtask

    task automatic t_zero_queue();
        sel_wr(2'd2);
        chk("R1 zero-depth full", full, 1);
        wr(16'h0400);
        sel_rd(2'd2);
        tick(); tick();
        chk("R1 zero-depth never valid", out_valid, 0);
        chk("R6 empty switch holds word", rd_data, 16'h0305);
        chk("R7 ae zero-depth", almost_empty, 1);
    endtask

    task automatic t_clamp_q3();
        sel_wr(2'd3);
        for (int i = 0; i < 20; i++) begin
            wr(16'h0500 + 16'(i));
            if (i == 18) chk("R1 clamped q3 not full at 19", full, 0);
            if (i == 19) chk("R1 clamped q3 full at 20", full, 1);
        end
        sel_rd(2'd3);
        tick();
        rd("R1 q3 head", 16'h0500);
        chk("R1 q3 second word", rd_data, 16'h0501);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_fill_drain_q0();
        t_select_latency();
        t_wrap_q1();
        t_same_queue_rw();
        t_zero_queue();
        t_clamp_q3();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule